// File: doc/BRIEF.md
# Float and Integer Conversion Unit

This unit converts a single 32-bit operand between two's-complement integer form and IEEE single-precision form. A two-bit operation code picks one of three conversions: integer to float (rounding to nearest, ties to even), float to integer rounding to nearest with ties moved away from zero, and float to integer truncating toward zero. The operand enters through a valid/ready handshake. A handshake takes place in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole conversion, so a valid offered during that time is simply not taken. The producer may hold it or withdraw it.

After a fixed number of cycles the unit presents a one-cycle completion strobe together with the result word and a set of condition flags. If the conversion is rejected instead, it presents an exception request with a cause code. The output side has no back-pressure: the consumer must capture the bundle in the strobe cycle. The output registers then hold their values until the next completion. Two sticky status bits record inexact and invalid conversions. Only reset clears them.

Float inputs with the exponent field (bits 30:23) all ones, and subnormal inputs (exponent field zero with a nonzero fraction), are treated as reserved and are rejected. Signed zeros are accepted.

Top module: `fcvt_unit`

## Requirements
- R1: `in_ready` is high whenever no conversion is pending. It goes low in the cycle after an operand is accepted and returns high in the completion cycle. A valid offered while `in_ready` is low starts nothing and changes no result.
- R2: `out_valid` is high for exactly one cycle. If an operand is accepted at clock edge k, the strobe is high in the cycle after edge k+16 for operation code 0, and in the cycle after edge k+14 for operation codes 1 and 2.
- R3: Operation code 0 converts a signed integer to single precision. It rounds to nearest with ties to even when more than 24 significant bits are present. Integer 0 gives 0x00000000, and -2147483648 gives 0xCF000000 exactly.
- R4: Operation code 1 converts a float to an integer by adding one half to the magnitude and truncating, so halfway values move away from zero.
- R5: Operation code 2 converts a float to an integer, truncating toward zero.
- R6: For codes 1 and 2, a reserved source (exponent field 0xFF, or exponent field 0 with a nonzero fraction) raises `out_exc` with cause 0xFF60. `out_wr` is low and neither sticky bit changes.
- R7: A code 1 conversion is invalid for values at or below -2147483648.5 or at or above 2147483647.5. A code 2 conversion is invalid for values at or below -2147483649.0 or at or above 2147483648.0. An invalid conversion raises cause 0xFF70, keeps `out_wr` low and sets `sticky_invalid`.
- R8: `sticky_inexact` is set by any completed conversion whose result differs in value from its source. Both sticky bits stay set until reset.
- R9: For codes 1 and 2 on success: `out_flag_ov` is 0, `out_flag_s` equals bit 31 of the result, `out_flag_z` is 1 only for a zero result, and `out_cy_upd` is 0 (carry left unchanged).
- R10: For code 0: `out_flag_cy` and `out_flag_s` both equal bit 31 of the result, `out_flag_ov` is 0, `out_flag_z` is 1 only for a zero result, and `out_cy_upd` is 1.
- R11: Operation code 3 is taken by the handshake but discarded. No completion follows and `in_ready` stays high.
- R12: After reset `in_ready` is 1, and `out_valid`, `sticky_inexact` and `sticky_invalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle and able to take an operand |
| in_op | input | 2 | Operation code: 0 int to float, 1 float to int rounded, 2 float to int truncated, 3 discarded |
| in_src | input | 32 | Source operand bits |
| out_valid | output | 1 | One-cycle completion strobe |
| out_result | output | 32 | Converted value |
| out_wr | output | 1 | Result should be written (no exception) |
| out_exc | output | 1 | Exception request |
| out_cause | output | 16 | Exception cause code |
| out_flag_z | output | 1 | Zero flag |
| out_flag_s | output | 1 | Sign flag |
| out_flag_ov | output | 1 | Overflow flag |
| out_flag_cy | output | 1 | Carry flag value |
| out_cy_upd | output | 1 | Carry flag should be updated |
| sticky_inexact | output | 1 | Sticky inexact status |
| sticky_invalid | output | 1 | Sticky invalid-conversion status |

## Verification
The bound checker checks the following on every cycle:
- the completion timing against a counter started at each accepted operand, separately for each operation code;
- the single-cycle strobe;
- the drop of `in_ready` after acceptance;
- that code 3 leaves the unit idle;
- that exceptions never write and carry only the two legal causes;
- the persistence of both sticky bits;
- the flag relations for overflow and carry.

The numerical results can only be shown by the bench's scenarios. These include:
- ties in both rounding styles;
- the integer extremes near ±2^31 on each side of the invalid bounds;
- reserved and signed-zero encodings;
- a valid offered mid-conversion that must leave the result unchanged;
- a stream of random operands compared against bench models.

// File: rtl/fcvt_pkg.sv
`timescale 1ns/1ps
package fcvt_pkg;
  localparam int WORD_W  = 32;
  localparam int CAUSE_W = 16;

  typedef enum logic [1:0] {
    OP_I2F     = 2'd0,
    OP_F2I_RND = 2'd1,
    OP_F2I_TRN = 2'd2,
    OP_NONE    = 2'd3
  } cvt_op_e;

  localparam logic [CAUSE_W-1:0] CAUSE_RESERVED = 16'hFF60;
  localparam logic [CAUSE_W-1:0] CAUSE_INVALID  = 16'hFF70;

  typedef struct packed {
    logic [WORD_W-1:0]  value;
    logic               wr;
    logic               exc;
    logic [CAUSE_W-1:0] cause;
    logic               fz;
    logic               fs;
    logic               fov;
    logic               fcy;
    logic               cy_upd;
    logic               inexact;
    logic               invalid;
  } cvt_res_t;
endpackage

// File: rtl/fcvt_f2i_core.sv
`timescale 1ns/1ps
// Single precision to signed integer, rounded (half away) or truncated.
module fcvt_f2i_core
  import fcvt_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  input  logic              trunc_mode,
  output cvt_res_t          res
);
  localparam int FRAC_W = 23;
  localparam int WIDE_W = 96;   // 32 integer bits + 64 fraction bits

  logic              sgn, rsv, huge, half, tail, oor;
  logic [7:0]        ex;
  logic [FRAC_W-1:0] fr;
  logic [FRAC_W:0]   sig;
  logic [WIDE_W-1:0] wide;
  logic [31:0]       ipart, ival;
  logic [32:0]       mag;

  always_comb begin
    sgn  = src[31];
    ex   = src[30:23];
    fr   = src[FRAC_W-1:0];
    sig  = {1'b1, fr};
    rsv  = (ex == 8'hFF) || (ex == 8'd0 && fr != '0);
    huge = (ex >= 8'd159);                 // magnitude at least 2^32
    wide = '0;
    if (ex >= 8'd86 && !huge)
      wide = {{(WIDE_W-FRAC_W-1){1'b0}}, sig} << (ex - 8'd86);
    else if (ex != 8'd0 && !huge)
      wide = {{(WIDE_W-1){1'b0}}, 1'b1};   // below 2^-40: only a sticky bit
    ipart = wide[95:64];
    half  = wide[63];
    tail  = |wide[62:0];
    mag   = trunc_mode ? {1'b0, ipart} : ({1'b0, ipart} + {32'd0, half});
    oor   = huge || (sgn ? (mag > 33'h080000000) : (mag >= 33'h080000000));
    ival  = sgn ? (32'd0 - mag[31:0]) : mag[31:0];

    res = '0;
    if (rsv) begin
      res.exc   = 1'b1;
      res.cause = CAUSE_RESERVED;
    end else if (oor) begin
      res.exc     = 1'b1;
      res.cause   = CAUSE_INVALID;
      res.invalid = 1'b1;
    end else begin
      res.value   = ival;
      res.wr      = 1'b1;
      res.fz      = (ival == 32'd0);
      res.fs      = ival[31];
      res.inexact = half | tail;
    end
  end
endmodule

// File: rtl/fcvt_i2f_core.sv
`timescale 1ns/1ps
// Signed integer to single precision, round to nearest even.
module fcvt_i2f_core
  import fcvt_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  output cvt_res_t          res
);
  localparam int MANT_W = 24;

  function automatic logic [4:0] lead_zeros(input logic [31:0] v);
    lead_zeros = 5'd0;
    for (int i = 0; i < 32; i++)
      if (v[i]) lead_zeros = 5'(31 - i);
  endfunction

  logic              sgn, guard, sticky, bump;
  logic [31:0]       mag, norm, packed_f;
  logic [4:0]        lz;
  logic [MANT_W-1:0] keep;
  logic [MANT_W:0]   sum;
  logic [7:0]        expo;
  logic [22:0]       frac;

  always_comb begin
    sgn    = src[31];
    mag    = sgn ? (32'd0 - src) : src;
    lz     = lead_zeros(mag);
    norm   = mag << lz;
    keep   = norm[31:8];
    guard  = norm[7];
    sticky = |norm[6:0];
    bump   = guard & (sticky | keep[0]);
    sum    = {1'b0, keep} + {{MANT_W{1'b0}}, bump};
    expo   = 8'd158 - {3'b0, lz} + {7'b0, sum[MANT_W]};
    frac   = sum[MANT_W] ? sum[23:1] : sum[22:0];
    packed_f = (mag == 32'd0) ? 32'd0 : {sgn, expo, frac};

    res         = '0;
    res.value   = packed_f;
    res.wr      = 1'b1;
    res.fz      = (packed_f == 32'd0);
    res.fs      = packed_f[31];
    res.fcy     = packed_f[31];
    res.cy_upd  = 1'b1;
    res.inexact = guard | sticky;
  end
endmodule

// File: rtl/fcvt_timer.sv
`timescale 1ns/1ps
// Busy window and completion timing for one conversion at a time.
module fcvt_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] count_init,
  output logic          busy,
  output logic          finish
);
  logic [CW-1:0] cnt;

  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= count_init;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fcvt_unit.sv
`timescale 1ns/1ps
module fcvt_unit
  import fcvt_pkg::*;
#(
  parameter int F2I_CYCLES = 14,
  parameter int I2F_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [31:0]  in_src,
  output logic         out_valid,
  output logic [31:0]  out_result,
  output logic         out_wr,
  output logic         out_exc,
  output logic [15:0]  out_cause,
  output logic         out_flag_z,
  output logic         out_flag_s,
  output logic         out_flag_ov,
  output logic         out_flag_cy,
  output logic         out_cy_upd,
  output logic         sticky_inexact,
  output logic         sticky_invalid
);
  localparam int MAX_LAT = (F2I_CYCLES > I2F_CYCLES) ? F2I_CYCLES : I2F_CYCLES;
  localparam int CW      = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;

  cvt_op_e           op_in, op_q;
  logic              busy, finish, start;
  logic [WORD_W-1:0] src_q;
  logic [CW-1:0]     count_init;
  cvt_res_t          f2i_res, i2f_res, sel, out_q;

  assign op_in      = cvt_op_e'(in_op);
  assign in_ready   = !busy;
  assign start      = in_valid && in_ready && (op_in != OP_NONE);
  assign count_init = (op_in == OP_I2F) ? CW'(I2F_CYCLES - 1) : CW'(F2I_CYCLES - 1);

  fcvt_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .count_init(count_init),
    .busy(busy), .finish(finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      op_q  <= OP_I2F;
    end else if (start) begin
      src_q <= in_src;
      op_q  <= op_in;
    end
  end

  fcvt_f2i_core u_f2i (.src(src_q), .trunc_mode(op_q == OP_F2I_TRN), .res(f2i_res));
  fcvt_i2f_core u_i2f (.src(src_q), .res(i2f_res));

  assign sel = (op_q == OP_I2F) ? i2f_res : f2i_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_q          <= '0;
      sticky_inexact <= 1'b0;
      sticky_invalid <= 1'b0;
    end else begin
      out_valid <= finish;
      if (finish) begin
        out_q          <= sel;
        sticky_inexact <= sticky_inexact | sel.inexact;
        sticky_invalid <= sticky_invalid | sel.invalid;
      end
    end
  end

  assign out_result  = out_q.value;
  assign out_wr      = out_q.wr;
  assign out_exc     = out_q.exc;
  assign out_cause   = out_q.cause;
  assign out_flag_z  = out_q.fz;
  assign out_flag_s  = out_q.fs;
  assign out_flag_ov = out_q.fov;
  assign out_flag_cy = out_q.fcy;
  assign out_cy_upd  = out_q.cy_upd;
endmodule

// File: rtl/fcvt_unit_chk.sv
`timescale 1ns/1ps
module fcvt_unit_chk #(
  parameter int F2I_CYCLES = 14,
  parameter int I2F_CYCLES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_op,
  input logic        out_valid,
  input logic        out_wr,
  input logic        out_exc,
  input logic [15:0] out_cause,
  input logic        out_flag_s,
  input logic        out_flag_ov,
  input logic        out_flag_cy,
  input logic        out_cy_upd,
  input logic        sticky_inexact,
  input logic        sticky_invalid
);
  localparam int MAX_LAT = (F2I_CYCLES > I2F_CYCLES) ? F2I_CYCLES : I2F_CYCLES;
  localparam int SW      = $clog2(MAX_LAT + 2) + 1;

  logic          acc_go;
  logic [SW-1:0] since, want;

  assign acc_go = in_valid && in_ready && (in_op != 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= '1;
      want  <= '0;
    end else if (acc_go) begin
      since <= '0;
      want  <= (in_op == 2'd0) ? SW'(I2F_CYCLES) : SW'(F2I_CYCLES);
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since == want));
  p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> !in_ready);
  p_drop_code3_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'd3) |=> (in_ready && !out_valid));
  p_exc_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exc) |-> !out_wr);
  p_cause_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exc) |-> (out_cause == 16'hFF60 || out_cause == 16'hFF70));
  p_inexact_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_inexact |=> sticky_inexact);
  p_invalid_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_invalid |=> sticky_invalid);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_flag_ov);
  p_carry_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cy_upd) |-> (out_flag_cy == out_flag_s));
endmodule

bind fcvt_unit fcvt_unit_chk #(.F2I_CYCLES(F2I_CYCLES), .I2F_CYCLES(I2F_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .out_valid(out_valid), .out_wr(out_wr), .out_exc(out_exc), .out_cause(out_cause),
  .out_flag_s(out_flag_s), .out_flag_ov(out_flag_ov), .out_flag_cy(out_flag_cy),
  .out_cy_upd(out_cy_upd), .sticky_inexact(sticky_inexact), .sticky_invalid(sticky_invalid)
);

// File: tb/fcvt_unit_test.sv
`timescale 1ns/1ps
module fcvt_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic [31:0] in_src = 32'd0;
  logic        in_ready, out_valid, out_wr, out_exc;
  logic [31:0] out_result;
  logic [15:0] out_cause;
  logic        out_flag_z, out_flag_s, out_flag_ov, out_flag_cy, out_cy_upd;
  logic        sticky_inexact, sticky_invalid;

  int total = 0;
  int fails = 0;
  bit exp_sinx = 0;
  bit exp_sinv = 0;

  always #2 clk = ~clk;

  fcvt_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic real pow2(input int n);
    real r = 1.0;
    if (n >= 0) repeat (n) r = r * 2.0;
    else repeat (-n) r = r / 2.0;
    return r;
  endfunction

  // integer to float by division into kept bits and remainder
  function automatic logic [31:0] m_i2f(input logic [31:0] x, output bit inex);
    logic [31:0] mag, m, rem, halfv;
    int p, sh;
    inex = 0;
    mag = x[31] ? -x : x;
    if (mag == 0) return 32'd0;
    p = 31;
    while (!mag[p]) p--;
    if (p <= 23) m = mag << (23 - p);
    else begin
      sh = p - 23;
      m = mag >> sh;
      rem = mag & ((32'd1 << sh) - 1);
      halfv = 32'd1 << (sh - 1);
      inex = (rem != 0);
      if (rem > halfv || (rem == halfv && m[0])) m = m + 1;
      if (m[24]) begin m = m >> 1; p = p + 1; end
    end
    return {x[31], 8'(127 + p), m[22:0]};
  endfunction

  // float to integer through real arithmetic; kind 0 ok, 1 reserved, 2 invalid
  function automatic logic [31:0] m_f2i(input logic [31:0] b, input bit trn,
                                        output int kind, output bit inex);
    int e;
    real v, r;
    integer w;
    e = b[30:23];
    kind = 0; inex = 0;
    if (e == 255 || (e == 0 && b[22:0] != 0)) begin kind = 1; return 32'd0; end
    v = (e == 0) ? 0.0 : (1.0 + $itor(b[22:0]) / 8388608.0) * pow2(e - 127);
    if (b[31]) v = -v;
    if (trn) begin
      if (v <= -2147483649.0 || v >= 2147483648.0) begin kind = 2; return 32'd0; end
      r = v;
    end else begin
      if (v <= -2147483648.5 || v >= 2147483647.5) begin kind = 2; return 32'd0; end
      r = (v < 0.0) ? v - 0.5 : v + 0.5;
    end
    w = $rtoi(r);
    inex = ($itor(w) != v);
    return w;
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [31:0] src, input bit noise);
    logic [31:0] ev;
    int kind, n, lat;
    bit inex, got;
    kind = 0;
    if (op == 2'd0) begin ev = m_i2f(src, inex); lat = 16; end
    else begin ev = m_f2i(src, op == 2'd2, kind, inex); lat = 14; end
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src = src;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 ready low while busy", {31'd0, in_ready}, 32'd0);
    n = 0; got = 0;
    while (!got && n < 40) begin
      if (noise && n < 5) begin
        in_valid = 1'b1; in_op = 2'd0; in_src = 32'h1234_5678;
      end else in_valid = 1'b0;
      if (out_valid) got = 1;
      else begin @(negedge clk); n++; end
    end
    in_valid = 1'b0;
    chk("R2 latency", n, lat);
    if (kind == 1) begin
      chk("R6 reserved exc", {31'd0, out_exc}, 32'd1);
      chk("R6 reserved cause", {16'd0, out_cause}, 32'h0000FF60);
      chk("R6 no write", {31'd0, out_wr}, 32'd0);
    end else if (kind == 2) begin
      exp_sinv = 1;
      chk("R7 invalid exc", {31'd0, out_exc}, 32'd1);
      chk("R7 invalid cause", {16'd0, out_cause}, 32'h0000FF70);
      chk("R7 no write", {31'd0, out_wr}, 32'd0);
    end else begin
      if (inex) exp_sinx = 1;
      chk(op == 2'd0 ? "R3 int to float" : (op == 2'd1 ? "R4 rounded" : "R5 truncated"),
          out_result, ev);
      chk("R9 R10 write", {31'd0, out_wr}, 32'd1);
      chk("R9 R10 zero flag", {31'd0, out_flag_z}, {31'd0, ev == 32'd0});
      chk("R9 R10 sign flag", {31'd0, out_flag_s}, {31'd0, ev[31]});
      chk("R9 R10 ov flag", {31'd0, out_flag_ov}, 32'd0);
      if (op == 2'd0) begin
        chk("R10 carry update", {31'd0, out_cy_upd}, 32'd1);
        chk("R10 carry flag", {31'd0, out_flag_cy}, {31'd0, ev[31]});
      end else chk("R9 carry kept", {31'd0, out_cy_upd}, 32'd0);
    end
    chk("R8 sticky inexact", {31'd0, sticky_inexact}, {31'd0, exp_sinx});
    chk("R7 R8 sticky invalid", {31'd0, sticky_invalid}, {31'd0, exp_sinv});
    if (noise) begin
      got = 0;
      repeat (24) begin @(negedge clk); if (out_valid) got = 1; end
      chk("R1 busy offer ignored", {31'd0, got}, 32'd0);
    end
  endtask

  function automatic logic [31:0] rand_float();
    logic [31:0] b;
    b = $urandom;
    case ($urandom % 16)
      0: b[30:23] = 8'hFF;
      1: b[30:23] = 8'h00;
      default: b[30:23] = 8'(100 + $urandom % 70);
    endcase
    return b;
  endfunction

  initial begin
    bit ig, seen;
    logic [31:0] h;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R12 reset ready", {31'd0, in_ready}, 32'd1);
    chk("R12 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R12 reset stickies", {30'd0, sticky_inexact, sticky_invalid}, 32'd0);
    rst_n = 1'b1;
    // exact cases first so stickies must stay clear
    do_op(2'd0, 32'd0, 0);
    do_op(2'd0, 32'h8000_0000, 0);         // R3 -2^31 exact
    do_op(2'd2, 32'hCF00_0000, 0);         // R5 -2^31 valid
    do_op(2'd1, 32'hCF00_0000, 0);         // R4 -2^31 valid
    do_op(2'd2, 32'h8000_0000, 0);         // negative zero
    do_op(2'd1, 32'h7F80_0000, 0);         // R6 infinity
    do_op(2'd2, 32'h0000_0001, 0);         // R6 subnormal
    // R11 code 3 discarded
    @(negedge clk); in_valid = 1'b1; in_op = 2'd3; in_src = 32'h4020_0000;
    @(negedge clk); in_valid = 1'b0;
    seen = 0;
    repeat (25) begin @(negedge clk); if (out_valid || !in_ready) seen = 1; end
    chk("R11 code 3 dropped", {31'd0, seen}, 32'd0);
    // rounding ties and inexact
    do_op(2'd1, 32'h4020_0000, 0);         // 2.5 -> 3
    do_op(2'd1, 32'hC020_0000, 0);         // -2.5 -> -3
    do_op(2'd2, 32'h4020_0000, 0);         // 2.5 -> 2
    do_op(2'd2, 32'hC030_0000, 0);         // -2.75 -> -2
    do_op(2'd1, 32'h3F00_0000, 0);         // 0.5 -> 1
    do_op(2'd1, 32'hBECC_CCCD, 0);         // -0.4 -> 0
    do_op(2'd0, 32'd16777217, 0);          // tie to even, down
    do_op(2'd0, 32'd16777219, 0);          // tie to even, up
    do_op(2'd0, 32'h7FFF_FFFF, 0);         // rounds to 2^31
    do_op(2'd1, 32'h4F00_0000, 0);         // R7 2^31 invalid
    do_op(2'd2, 32'h4F00_0000, 0);
    do_op(2'd0, 32'hFFFF_FFF9, 1);         // R1 offer while busy
    for (int i = 0; i < 240; i++) begin
      case (i % 4)
        0: do_op(2'd0, $urandom >> ($urandom % 32), 0);
        1: do_op(2'd1, rand_float(), 0);
        2: do_op(2'd2, rand_float(), 0);
        default: begin
          h = m_i2f(2 * ($urandom % 4194304) + 1, ig);
          h[30:23] = h[30:23] - 8'd1;        // exact k + 0.5
          h[31] = $urandom % 2;
          do_op(2'(1 + i % 2), h, 0);
        end
      endcase
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule